// File: doc/BRIEF.md
# Display Controller PCI Configuration Register File

This block holds the type-0 PCI configuration header of a display controller. It is byte-addressed. An 8-bit offset selects a byte. A write strobe with a data byte updates that byte on the next clock edge. A purely combinational read port always shows the byte at the current offset.

The header holds these items:
- the command byte;
- three sticky error flags in the status byte, which software clears by writing ones;
- the base of a 16 MB linear frame-buffer aperture;
- an expansion-ROM base with its enable bit;
- the interrupt-line byte;
- subsystem identifiers that software can write.

Apart from the register file, the block drives the decode enables for four windows:
- the legacy VGA I/O window;
- the legacy VGA memory window;
- the linear aperture;
- the ROM window.

It also compares one 32-bit probe address against each enabled window and raises a hit for every window that contains it. A strap input marks a controller soldered onto the board with no option ROM. While the strap is high, the ROM registers are frozen and the ROM window stays off.

Top module: `vidcfg_space`

## Requirements
- R1: Fixed bytes read as follows: offset 0x00 = 0x2C, 0x01 = 0x10, 0x02 = 0xC0, 0x03 = 0x00, 0x06 = 0x80, 0x0B = 0x03, 0x3D = 0x01. Every offset not named in R1 to R11 reads 0x00 and ignores writes, and writes to the fixed bytes are ignored.
- R2: A write to offset 0x04 stores the whole byte. A read of 0x04 returns (stored AND 0x73) OR 0x80. Bit 0 of this byte is the I/O enable and bit 1 is the memory enable.
- R3: Offset 0x05 keeps only bit 0 of the written data and reads it back, with bits 7:1 reading zero.
- R4: Status byte 0x07, bit 1 always reads 1. Bits 3, 6 and 7 are set by a one on `err_evt[0]`, `err_evt[1]` and `err_evt[2]` respectively. A write clears each of these bits whose data bit is 1. A flag raised in the same cycle as a clear stays set. No other bit of the byte can be written.
- R5: Offset 0x13 is read/write and holds address bits 31:24 of the linear aperture. `lin_win_en` is high only when the memory enable is set and the base is non-zero. `lin_hit` is high when `lin_win_en` is high and `probe_addr[31:24]` equals the base.
- R6: Offset 0x30 holds the ROM enable in bit 0 and reads it back, with bits 7:1 reading zero. Offset 0x31 reads 0x00. Offset 0x32 stores data AND 0xFC. Offset 0x33 stores the full byte. Together, 0x33:0x32 form ROM base bits 31:16. `rom_win_en` is high when the memory enable and the ROM enable are both set. `rom_hit` is high when `rom_win_en` is high and `probe_addr[31:16]` equals the base.
- R7: While `onboard_strap` is high, writes to 0x30, 0x32 and 0x33 leave those bytes unchanged, and `rom_win_en` and `rom_hit` are low.
- R8: `io_win_en` follows command bit 0. `io_hit` is high for probe addresses 0x3C0 to 0x3DF inclusive while it is enabled. `vga_win_en` follows command bit 1. `vga_hit` is high for 0xA0000 to 0xBFFFF while it is enabled.
- R9: The subsystem vendor ID resets to 0x102C and the subsystem device ID resets to 0x00C0. Software writes them little-endian: the vendor ID at 0x6C (low byte) and 0x6D (high byte), the device ID at 0x6E (low) and 0x6F (high). Each byte reads back at both 0x6C–0x6F and the matching offset 0x2C–0x2F. Writes to 0x2C–0x2F are ignored.
- R10: A synchronous active-high reset clears the command, 0x05, status, linear base, ROM enable, ROM base and interrupt-line bytes, and restores the subsystem defaults. After reset every window enable and hit is low.
- R11: Offset 0x3C is a plain read/write interrupt-line byte.
- R12: The read data is combinational from the offset. During a write cycle it shows the old value, and the new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data at `cfg_off` |
| err_evt | input | 3 | Error events that set status bits 3, 6, 7 |
| onboard_strap | input | 1 | High when the controller has no option ROM |
| probe_addr | input | 32 | Address compared against the windows |
| io_win_en | output | 1 | VGA I/O window enabled |
| vga_win_en | output | 1 | Legacy VGA memory window enabled |
| lin_win_en | output | 1 | Linear aperture enabled |
| rom_win_en | output | 1 | ROM window enabled |
| io_hit | output | 1 | Probe inside the enabled I/O window |
| vga_hit | output | 1 | Probe inside the enabled VGA memory window |
| lin_hit | output | 1 | Probe inside the enabled linear aperture |
| rom_hit | output | 1 | Probe inside the enabled ROM window |

## Verification
The bench probes the edges of each window:
- I/O window: 0x3BF, 0x3C0, 0x3DF and 0x3E0. A wrong bound would decode a neighbouring legacy port or miss the last VGA register.
- Linear aperture: a zero base with the memory enable set, which a careless design would decode at address 0.
- ROM window: the strap must hold the ROM bytes and the window off, even when the enables would otherwise open it.

It also covers these register behaviours:
- Status byte: write-one-to-clear bits are cleared selectively, and an event that arrives in the same cycle as a clear must survive. A design that lets the clear win loses an error report.
- Subsystem alias: a write to the read-only copy at 0x2C–0x2F must not take effect.
- Read port: during a write it must still show the old byte, so a design that bypasses write data onto the read port is caught.

// File: rtl/vidcfg_space.sv
module vidcfg_space #(
  parameter logic [15:0] SUB_VID_RST = 16'h102C,
  parameter logic [15:0] SUB_DID_RST = 16'h00C0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  cfg_off,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic [2:0]  err_evt,
  input  logic        onboard_strap,
  input  logic [31:0] probe_addr,
  output logic        io_win_en,
  output logic        vga_win_en,
  output logic        lin_win_en,
  output logic        rom_win_en,
  output logic        io_hit,
  output logic        vga_hit,
  output logic        lin_hit,
  output logic        rom_hit
);

  logic [7:0]  cmd_q, b05_q, stat_q, lin_base_q, irq_line_q;
  logic        rom_en_q;
  logic [15:0] rom_base_q, sub_vid_q, sub_did_q;

  wire wr = cfg_we;
  wire rom_wr_ok = !onboard_strap;
  wire [7:0] err_bits = {err_evt[2], err_evt[1], 2'b00, err_evt[0], 3'b000};
  wire [7:0] clr_bits = (wr && cfg_off == 8'h07) ? (cfg_wdata & 8'hC8) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      b05_q      <= '0;
      stat_q     <= '0;
      lin_base_q <= '0;
      irq_line_q <= '0;
      rom_en_q   <= 1'b0;
      rom_base_q <= '0;
      sub_vid_q  <= SUB_VID_RST;
      sub_did_q  <= SUB_DID_RST;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | err_bits;
      if (wr) begin
        case (cfg_off)
          8'h04: cmd_q      <= cfg_wdata;
          8'h05: b05_q      <= {7'd0, cfg_wdata[0]};
          8'h13: lin_base_q <= cfg_wdata;
          8'h30: if (rom_wr_ok) rom_en_q <= cfg_wdata[0];
          8'h32: if (rom_wr_ok) rom_base_q[7:0]  <= cfg_wdata & 8'hFC;
          8'h33: if (rom_wr_ok) rom_base_q[15:8] <= cfg_wdata;
          8'h3C: irq_line_q <= cfg_wdata;
          8'h6C: sub_vid_q[7:0]  <= cfg_wdata;
          8'h6D: sub_vid_q[15:8] <= cfg_wdata;
          8'h6E: sub_did_q[7:0]  <= cfg_wdata;
          8'h6F: sub_did_q[15:8] <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_off)
      8'h00:        cfg_rdata = 8'h2C;
      8'h01:        cfg_rdata = 8'h10;
      8'h02:        cfg_rdata = 8'hC0;
      8'h04:        cfg_rdata = (cmd_q & 8'h73) | 8'h80;
      8'h05:        cfg_rdata = b05_q;
      8'h06:        cfg_rdata = 8'h80;
      8'h07:        cfg_rdata = stat_q | 8'h02;
      8'h0B:        cfg_rdata = 8'h03;
      8'h13:        cfg_rdata = lin_base_q;
      8'h2C, 8'h6C: cfg_rdata = sub_vid_q[7:0];
      8'h2D, 8'h6D: cfg_rdata = sub_vid_q[15:8];
      8'h2E, 8'h6E: cfg_rdata = sub_did_q[7:0];
      8'h2F, 8'h6F: cfg_rdata = sub_did_q[15:8];
      8'h30:        cfg_rdata = {7'd0, rom_en_q};
      8'h32:        cfg_rdata = rom_base_q[7:0];
      8'h33:        cfg_rdata = rom_base_q[15:8];
      8'h3C:        cfg_rdata = irq_line_q;
      8'h3D:        cfg_rdata = 8'h01;
      default:      cfg_rdata = 8'h00;
    endcase
  end

  assign io_win_en  = cmd_q[0];
  assign vga_win_en = cmd_q[1];
  assign lin_win_en = cmd_q[1] && (lin_base_q != 8'h00);
  assign rom_win_en = cmd_q[1] && rom_en_q && !onboard_strap;

  assign io_hit  = io_win_en  && (probe_addr >= 32'h0000_03C0) && (probe_addr <= 32'h0000_03DF);
  assign vga_hit = vga_win_en && (probe_addr >= 32'h000A_0000) && (probe_addr <= 32'h000B_FFFF);
  assign lin_hit = lin_win_en && (probe_addr[31:24] == lin_base_q);
  assign rom_hit = rom_win_en && (probe_addr[31:16] == rom_base_q);

  // R2
  cmd_io_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_off == 8'h04) |=> (io_win_en == $past(cfg_wdata[0])));

  // R4
  stat_evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    err_evt[2] |=> stat_q[7]);

  // R5
  lin_base_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_off == 8'h13) |=> (lin_base_q == $past(cfg_wdata)));

  // R7
  strap_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (onboard_strap && cfg_we && (cfg_off == 8'h30 || cfg_off == 8'h32 || cfg_off == 8'h33))
      |=> ($stable(rom_base_q) && $stable(rom_en_q)));

  // R7
  strap_no_rom_chk: assert property (@(posedge clk) disable iff (rst)
    onboard_strap |-> !rom_hit);

  // R9
  sub_alias_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_off[7:2] == 6'b001011) |=> ($stable(sub_vid_q) && $stable(sub_did_q)));

endmodule

// File: tb/vidcfg_space_test.sv
module vidcfg_space_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_off = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [2:0]  err_evt = '0;
  logic        onboard_strap = 1'b0;
  logic [31:0] probe_addr = '0;
  logic io_win_en, vga_win_en, lin_win_en, rom_win_en;
  logic io_hit, vga_hit, lin_hit, rom_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vidcfg_space uut (
    .clk(clk), .rst(rst), .cfg_off(cfg_off), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .err_evt(err_evt), .onboard_strap(onboard_strap),
    .probe_addr(probe_addr), .io_win_en(io_win_en), .vga_win_en(vga_win_en),
    .lin_win_en(lin_win_en), .rom_win_en(rom_win_en), .io_hit(io_hit),
    .vga_hit(vga_hit), .lin_hit(lin_hit), .rom_hit(rom_hit));

  // entry: {is_write, offset, data}; a read entry checks data as expected value
  localparam int NV = 45;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h2C}, {1'b0, 8'h01, 8'h10}, {1'b0, 8'h02, 8'hC0}, {1'b0, 8'h03, 8'h00},
    {1'b0, 8'h0B, 8'h03}, {1'b0, 8'h3D, 8'h01}, {1'b0, 8'h06, 8'h80}, {1'b0, 8'h07, 8'h02},
    {1'b0, 8'h04, 8'h80}, {1'b0, 8'h2C, 8'h2C}, {1'b0, 8'h2D, 8'h10}, {1'b0, 8'h2E, 8'hC0},
    {1'b0, 8'h2F, 8'h00}, {1'b0, 8'h6C, 8'h2C},
    {1'b1, 8'h04, 8'hFF}, {1'b0, 8'h04, 8'hF3},
    {1'b1, 8'h05, 8'hFF}, {1'b0, 8'h05, 8'h01},
    {1'b1, 8'h13, 8'hA5}, {1'b0, 8'h13, 8'hA5},
    {1'b1, 8'h3C, 8'h0B}, {1'b0, 8'h3C, 8'h0B},
    {1'b1, 8'h6C, 8'h34}, {1'b1, 8'h6D, 8'h12}, {1'b0, 8'h2C, 8'h34}, {1'b0, 8'h2D, 8'h12},
    {1'b0, 8'h6D, 8'h12},
    {1'b1, 8'h6E, 8'h78}, {1'b1, 8'h6F, 8'h56}, {1'b0, 8'h2E, 8'h78}, {1'b0, 8'h6F, 8'h56},
    {1'b1, 8'h2C, 8'h00}, {1'b0, 8'h2C, 8'h34},
    {1'b1, 8'h30, 8'hFF}, {1'b0, 8'h30, 8'h01}, {1'b0, 8'h31, 8'h00},
    {1'b1, 8'h32, 8'hFF}, {1'b0, 8'h32, 8'hFC},
    {1'b1, 8'h33, 8'hC1}, {1'b0, 8'h33, 8'hC1},
    {1'b1, 8'h50, 8'hAA}, {1'b0, 8'h50, 8'h00},
    {1'b1, 8'h06, 8'h00}, {1'b0, 8'h06, 8'h80}, {1'b0, 8'h05, 8'h01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_off = off; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] off, input logic [7:0] exp);
    cfg_off = off;
    #1;
    chk(req, {24'd0, cfg_rdata}, {24'd0, exp});
  endtask

  task automatic probe(input logic [31:0] a);
    probe_addr = a;
    #1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    probe(32'h0000_03C0);
    chk("R10 enables after reset", {28'd0, io_win_en, vga_win_en, lin_win_en, rom_win_en}, 32'd0);
    chk("R10 io_hit after reset", {31'd0, io_hit}, 32'd0);
    probe(32'h000A_0000);
    chk("R10 vga_hit after reset", {31'd0, vga_hit}, 32'd0);

    // table: R1 R2 R3 R5 R6 R9 R11
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) wr(VEC[i][15:8], VEC[i][7:0]);
      else begin
        @(negedge clk);
        rd("R1/R2/R3/R5/R6/R9/R11 table", VEC[i][15:8], VEC[i][7:0]);
      end
    end

    // R8 I/O window edges, cmd = FF
    @(negedge clk);
    probe(32'h0000_03BF); chk("R8 io below", {31'd0, io_hit}, 32'd0);
    probe(32'h0000_03C0); chk("R8 io low edge", {31'd0, io_hit}, 32'd1);
    probe(32'h0000_03DF); chk("R8 io high edge", {31'd0, io_hit}, 32'd1);
    probe(32'h0000_03E0); chk("R8 io above", {31'd0, io_hit}, 32'd0);
    probe(32'h000A_0000); chk("R8 vga low edge", {31'd0, vga_hit}, 32'd1);
    probe(32'h000B_FFFF); chk("R8 vga high edge", {31'd0, vga_hit}, 32'd1);
    probe(32'h000C_0000); chk("R8 vga above", {31'd0, vga_hit}, 32'd0);
    // R5 linear aperture at 0xA5
    probe(32'hA512_3456); chk("R5 lin hit", {31'd0, lin_hit}, 32'd1);
    probe(32'hA600_0000); chk("R5 lin miss", {31'd0, lin_hit}, 32'd0);
    // R6 ROM window at 0xC1FC
    probe(32'hC1FC_1234); chk("R6 rom hit", {31'd0, rom_hit}, 32'd1);
    probe(32'hC1FD_0000); chk("R6 rom miss", {31'd0, rom_hit}, 32'd0);

    // R2 command gating
    wr(8'h04, 8'h02);
    probe(32'h0000_03C0); chk("R2 io off when bit0 clear", {31'd0, io_hit}, 32'd0);
    probe(32'hA500_0000); chk("R2 lin on with bit1", {31'd0, lin_hit}, 32'd1);
    wr(8'h04, 8'h01);
    probe(32'h0000_03C0); chk("R2 io on with bit0", {31'd0, io_hit}, 32'd1);
    probe(32'hA500_0000); chk("R2 lin off when bit1 clear", {31'd0, lin_hit}, 32'd0);
    probe(32'hC1FC_0000); chk("R6 rom off when bit1 clear", {31'd0, rom_hit}, 32'd0);

    // R5 zero base never decodes
    wr(8'h04, 8'h03);
    wr(8'h13, 8'h00);
    probe(32'h0000_0000); chk("R5 zero base lin_hit", {31'd0, lin_hit}, 32'd0);
    chk("R5 zero base lin_win_en", {31'd0, lin_win_en}, 32'd0);

    // R7 strap
    onboard_strap = 1'b1;
    probe(32'hC1FC_0000); chk("R7 strap blocks rom_hit", {31'd0, rom_hit}, 32'd0);
    chk("R7 strap blocks rom_win_en", {31'd0, rom_win_en}, 32'd0);
    wr(8'h33, 8'h00);
    wr(8'h32, 8'h00);
    wr(8'h30, 8'h00);
    rd("R7 strap holds 0x33", 8'h33, 8'hC1);
    rd("R7 strap holds 0x32", 8'h32, 8'hFC);
    rd("R7 strap holds 0x30", 8'h30, 8'h01);
    onboard_strap = 1'b0;
    probe(32'hC1FC_0000); chk("R7 strap released rom_hit", {31'd0, rom_hit}, 32'd1);

    // R4 status flags
    @(negedge clk); err_evt = 3'b111;
    @(negedge clk); err_evt = 3'b000;
    rd("R4 flags set", 8'h07, 8'hCA);
    wr(8'h07, 8'h40);
    rd("R4 clear bit6 only", 8'h07, 8'h8A);
    wr(8'h07, 8'h88);
    rd("R4 clear rest", 8'h07, 8'h02);
    wr(8'h07, 8'hFF);
    rd("R4 clear with no flags", 8'h07, 8'h02);
    @(negedge clk);
    cfg_off = 8'h07; cfg_wdata = 8'h08; cfg_we = 1'b1; err_evt = 3'b001;
    @(negedge clk);
    cfg_we = 1'b0; err_evt = 3'b000;
    rd("R4 event beats clear", 8'h07, 8'h0A);

    // R12 read shows old value during write
    @(negedge clk);
    cfg_off = 8'h3C; cfg_wdata = 8'h55; cfg_we = 1'b1;
    #1;
    chk("R12 old value during write", {24'd0, cfg_rdata}, 32'h0B);
    @(negedge clk);
    cfg_we = 1'b0;
    rd("R12 new value after edge", 8'h3C, 8'h55);

    // R10 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd("R10 cmd after reset", 8'h04, 8'h80);
    rd("R10 lin base after reset", 8'h13, 8'h00);
    rd("R10 sub vid restored", 8'h2C, 8'h2C);
    rd("R10 sub did restored", 8'h6E, 8'hC0);
    rd("R10 rom base cleared", 8'h33, 8'h00);
    rd("R11 irq line cleared", 8'h3C, 8'h00);
    probe(32'h0000_03C0);
    chk("R10 io_hit off after reset", {31'd0, io_hit}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule